// File: doc/BRIEF.md
# Buffered Mode-0 Parallel Port Group

This block provides one 24-line group of a classic programmable parallel port that only ever runs in its basic I/O mode. The lines split into two byte-wide ports, A and B, and a third byte-wide port C whose upper and lower halves each carry their own direction. A host reaches the group through four byte offsets. Offsets 0 to 2 are the data ports. Offset 3 holds the write-only control byte that sets the direction of each of the four ports.

The pins sit behind external bidirectional buffers. The block drives a registered output-enable for each port and a set of output values, and it receives the live pin levels back. Output data is held in latches. A latch accepts host writes in either direction, so a value written while a port is an input appears on the pins once that port turns into an output. The latches come out of reset all ones, so a port that becomes an output before it has been written drives high. The single-bit set/reset command of the classic part is not provided.

Top module: `pio_group`

## Requirements
- R1: While and after reset, with no host write, every port is an input (dirOut = 4'b0000) and pinOut is all ones (0xFFFFFF).
- R2: Host offsets are decoded as 0 = port A (pin bits 7:0), 1 = port B (pin bits 15:8), 2 = port C (pin bits 23:16, upper half C7..C4 at pin bits 23:20, lower half C3..C0 at pin bits 19:16), 3 = control.
- R3: A control write with bit 7 set loads the directions: bit 4 for port A, bit 1 for port B, bit 3 for upper C, bit 0 for lower C, 1 meaning input. dirOut bit 0 enables A, bit 1 enables B, bit 2 enables lower C, bit 3 enables upper C (1 = output). For example, 0x98 gives dirOut = 4'b0110.
- R4: A control write with bit 7 clear has no effect on any direction.
- R5: dirOut changes only on the clock edge that takes in the control write; before that edge it keeps its old value.
- R6: A read of a port set as input returns the live pin levels of that port, with no latching.
- R7: A read of a port set as output returns that port's output latch.
- R8: A read of port C returns each half from its latch when that half is an output and from the pins when it is an input.
- R9: A write to a port set as input is stored in its latch, and the stored value is driven once the port is made an output.
- R10: A port switched to output with no prior write drives all ones.
- R11: A read of offset 3 returns 0x00.
- R12: A port write appears on pinOut at the clock edge that takes in the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 2 | Register offset for both reads and writes |
| hostWr | input | 1 | Write strobe, one write per cycle it is high |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data for hostAddr, combinational |
| pinIn | input | 24 | Live pin levels from the buffers |
| pinOut | output | 24 | Latched output values toward the buffers |
| dirOut | output | 4 | Per-port buffer output enables |

## Verification
The main function is swept over all sixteen direction combinations. Each combination gets its own control byte, its own latch values and a pin pattern whose bits differ from the latch bits, so every read shows whether a half came from the pins or from the latch. A fixed sequence covers the path from reset: output with no write (all ones), a control byte with bit 7 clear, the 0x98 example, and a write to an input port that is later driven. The control writes are checked just before and just after the edge that takes them in, which separates a registered enable from a combinational one.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    OFF_A   = 2'd0,
    OFF_B   = 2'd1,
    OFF_C   = 2'd2,
    OFF_CTL = 2'd3
  } regOff_e;

  // control byte bit positions (1 = input)
  localparam int CTL_EN_BIT = 7;
  localparam int CTL_A_BIT  = 4;
  localparam int CTL_B_BIT  = 1;
  localparam int CTL_CU_BIT = 3;
  localparam int CTL_CL_BIT = 0;

  // dirOut bit positions (1 = output)
  localparam int DIR_A  = 0;
  localparam int DIR_B  = 1;
  localparam int DIR_CL = 2;
  localparam int DIR_CU = 3;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic wrCtl;
  } strobe_t;

endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              hostWr,
  input  logic [1:0]        hostAddr,
  input  logic              ctlEnable,
  output strobe_t           stb
);

  always_comb begin
    stb       = '0;
    stb.wrA   = hostWr && (hostAddr == OFF_A);
    stb.wrB   = hostWr && (hostAddr == OFF_B);
    stb.wrC   = hostWr && (hostAddr == OFF_C);
    stb.wrCtl = hostWr && (hostAddr == OFF_CTL) && ctlEnable;
  end

endmodule

// File: rtl/pio_data.sv
module pio_data
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [1:0]          rdAddr,
  input  logic [PORT_W-1:0]   wrData,
  input  logic [3*PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0]   rdData,
  output logic [3*PORT_W-1:0] pinOut,
  output logic [3:0]          dirOut
);

  localparam int NIB_W = PORT_W / 2;

  logic [PORT_W-1:0] latA, latB, latC;
  logic [3:0]        dirQ;
  logic [PORT_W-1:0] pinA, pinB, pinC;
  logic [PORT_W-1:0] rdC;

  assign pinA = pinIn[PORT_W-1:0];
  assign pinB = pinIn[2*PORT_W-1:PORT_W];
  assign pinC = pinIn[3*PORT_W-1:2*PORT_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latA <= '1;
      latB <= '1;
      latC <= '1;
      dirQ <= '0;
    end else begin
      if (stb.wrA) latA <= wrData;
      if (stb.wrB) latB <= wrData;
      if (stb.wrC) latC <= wrData;
      if (stb.wrCtl) begin
        dirQ[DIR_A]  <= ~wrData[CTL_A_BIT];
        dirQ[DIR_B]  <= ~wrData[CTL_B_BIT];
        dirQ[DIR_CL] <= ~wrData[CTL_CL_BIT];
        dirQ[DIR_CU] <= ~wrData[CTL_CU_BIT];
      end
    end
  end

  assign rdC = {dirQ[DIR_CU] ? latC[PORT_W-1:NIB_W] : pinC[PORT_W-1:NIB_W],
                dirQ[DIR_CL] ? latC[NIB_W-1:0]      : pinC[NIB_W-1:0]};

  always_comb begin
    case (rdAddr)
      OFF_A:   rdData = dirQ[DIR_A] ? latA : pinA;
      OFF_B:   rdData = dirQ[DIR_B] ? latB : pinB;
      OFF_C:   rdData = rdC;
      default: rdData = '0;
    endcase
  end

  assign pinOut = {latC, latB, latA};
  assign dirOut = dirQ;

endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          hostAddr,
  input  logic                hostWr,
  input  logic [PORT_W-1:0]   hostWrData,
  output logic [PORT_W-1:0]   hostRdData,
  input  logic [3*PORT_W-1:0] pinIn,
  output logic [3*PORT_W-1:0] pinOut,
  output logic [3:0]          dirOut
);

  strobe_t stb;

  pio_ctrl #(.PORT_W(PORT_W)) ctrl_i (
    .hostWr    (hostWr),
    .hostAddr  (hostAddr),
    .ctlEnable (hostWrData[CTL_EN_BIT]),
    .stb       (stb)
  );

  pio_data #(.PORT_W(PORT_W)) data_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdAddr (hostAddr),
    .wrData (hostWrData),
    .pinIn  (pinIn),
    .rdData (hostRdData),
    .pinOut (pinOut),
    .dirOut (dirOut)
  );

endmodule

// File: rtl/pio_group_chk.sv
module pio_group_chk #(
  parameter int PORT_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          hostAddr,
  input logic                hostWr,
  input logic [PORT_W-1:0]   hostWrData,
  input logic [PORT_W-1:0]   hostRdData,
  input logic [3*PORT_W-1:0] pinIn,
  input logic [3*PORT_W-1:0] pinOut,
  input logic [3:0]          dirOut
);

  // R3: enabled control write loads the four directions
  a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd3 && hostWrData[7]) |=>
      dirOut == {~$past(hostWrData[3]), ~$past(hostWrData[0]),
                 ~$past(hostWrData[1]), ~$past(hostWrData[4])});

  // R4 / R5: without an enabled control write the directions hold
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostAddr == 2'd3 && hostWrData[7]) |=> $stable(dirOut));

  // R6: input port A reads pins
  a_r6_read_pins: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd0 && !dirOut[0]) |-> hostRdData == pinIn[PORT_W-1:0]);

  // R7: output port B reads latch as driven
  a_r7_read_latch: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd1 && dirOut[1]) |-> hostRdData == pinOut[2*PORT_W-1:PORT_W]);

  // R11: control offset reads zero
  a_r11_ctl_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == 2'd3) |-> hostRdData == '0);

  // R12: port A write reaches pinOut at the next edge
  a_r12_write_a: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 2'd0) |=> pinOut[PORT_W-1:0] == $past(hostWrData));

  // R9: with no host write the latches hold
  a_r9_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !hostWr |=> $stable(pinOut));

endmodule

bind pio_group pio_group_chk #(.PORT_W(PORT_W)) chk_i (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
  .hostWrData(hostWrData), .hostRdData(hostRdData), .pinIn(pinIn),
  .pinOut(pinOut), .dirOut(dirOut)
);

// File: tb/pio_group_tb.sv
module pio_group_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic        hostWr = 1'b0;
  logic [7:0]  hostWrData = 8'd0;
  logic [7:0]  hostRdData;
  logic [23:0] pinIn = 24'd0;
  logic [23:0] pinOut;
  logic [3:0]  dirOut;

  int nChk = 0;
  int nErr = 0;
  logic [3:0]  expDir;
  logic [23:0] expLat;

  always #2.5 clk = ~clk;

  pio_group dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .pinIn(pinIn),
    .pinOut(pinOut), .dirOut(dirOut)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [1:0] a);
    case (a)
      2'd0: return expDir[0] ? expLat[7:0]  : pinIn[7:0];
      2'd1: return expDir[1] ? expLat[15:8] : pinIn[15:8];
      2'd2: return {expDir[3] ? expLat[23:20] : pinIn[23:20],
                    expDir[2] ? expLat[19:16] : pinIn[19:16]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic wrPort(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
    case (a)
      2'd0: expLat[7:0]   = d;
      2'd1: expLat[15:8]  = d;
      2'd2: expLat[23:16] = d;
      default: ;
    endcase
  endtask

  task automatic wrCtl(input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 2'd3; hostWrData = d;
    #1 chk("R5 dir before edge", {20'd0, dirOut}, {20'd0, expDir});
    @(negedge clk);
    hostWr = 1'b0;
    if (d[7]) expDir = {~d[3], ~d[0], ~d[1], ~d[4]};
    chk("R3/R4 dir after edge", {20'd0, dirOut}, {20'd0, expDir});
  endtask

  task automatic rdAll(input string req);
    for (int a = 0; a < 4; a++) begin
      hostAddr = a[1:0];
      #1 chk(req, {16'd0, hostRdData}, {16'd0, expRd(a[1:0])});
    end
  endtask

  initial begin
    expDir = 4'b0000;
    expLat = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk("R1 reset dir", {20'd0, dirOut}, 24'd0);
    chk("R1 reset pinOut", pinOut, 24'hFFFFFF);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset dir", {20'd0, dirOut}, 24'd0);
    pinIn = 24'h3C_A5_0F;
    rdAll("R6 inputs read pins");

    // R10: outputs with no prior write drive high
    pinIn = 24'h000000;
    wrCtl(8'h80);
    chk("R10 default high pins", pinOut, 24'hFFFFFF);
    rdAll("R10 default high reads");

    // R4: control byte without bit 7 changes nothing
    wrCtl(8'h1B);
    chk("R4 ignored ctrl", {20'd0, dirOut}, 24'h00000F);

    // R3: example byte
    wrCtl(8'h98);
    chk("R3 0x98 example", {20'd0, dirOut}, 24'h000006);

    // R9: write to input port A, then make it an output
    pinIn = 24'h0000C3;
    wrPort(2'd0, 8'h5A);
    hostAddr = 2'd0;
    #1 chk("R9 input A still reads pins", {16'd0, hostRdData}, 24'h0000C3);
    wrCtl(8'h88);
    chk("R9 stored value driven", {16'd0, pinOut[7:0]}, 24'h00005A);
    hostAddr = 2'd0;
    #1 chk("R9 stored value read", {16'd0, hostRdData}, 24'h00005A);

    // sweep all direction combinations, bit = 1 means input
    for (int cmb = 0; cmb < 16; cmb++) begin
      logic [7:0] cb;
      logic [7:0] va, vb, vc;
      cb = 8'h80 | (cmb[0] ? 8'h10 : 8'h00) | (cmb[1] ? 8'h02 : 8'h00)
                 | (cmb[2] ? 8'h01 : 8'h00) | (cmb[3] ? 8'h08 : 8'h00);
      wrCtl(cb);
      chk("R3 sweep dir", {20'd0, dirOut}, {20'd0, ~cmb[3:0]});
      va = 8'(cmb * 17 + 1);
      vb = ~va;
      vc = 8'(cmb * 29 + 7);
      wrPort(2'd0, va);
      chk("R12 pinOut A", {16'd0, pinOut[7:0]}, {16'd0, va});
      wrPort(2'd1, vb);
      chk("R12 pinOut B", {16'd0, pinOut[15:8]}, {16'd0, vb});
      wrPort(2'd2, vc);
      chk("R12 pinOut C", {16'd0, pinOut[23:16]}, {16'd0, vc});
      pinIn = ~{vc, vb, va};
      rdAll("R2/R6/R7/R8/R11 sweep read");
      pinIn = {vc ^ 8'h5A, vb ^ 8'hA5, va ^ 8'h3C};
      rdAll("R8 sweep read second pattern");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin
    #1000000;
    nErr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule